// File: doc/BRIEF.md
# Three-Wire Synthesiser Programming Interface

This block takes configuration for a dual frequency synthesiser over a three-wire bus made of a serial data line, a serial clock and a load strobe. Bits are shifted in most significant bit first on rising serial clock edges. When the strobe rises, the word in the shift register is moved into the working register it addresses. All three bus lines are first synchronised to the system clock, and every edge is detected in that domain.

The two least significant bits of a 24-bit word select its destination. Code 00 is the main divider word, code 01 the staged word, code 10 the auxiliary word and code 11 the control word. A 32-bit word, recognised by its length alone, is the extended main word. It carries the main divider field and also an 8-bit proportional-current scale in its top byte. The staged word is held in a shadow register and reaches its output only when a later main or extended main word is strobed, so that both halves of a new frequency take effect on the same edge. While the strobe stays high after a main or extended main load, the block asserts a speed-up flag that drives the fast-lock window of the loop.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, every working register output, the staged word output and `speedup` are zero.
- R2: A 24-bit word sent MSB first with address bits[1:0] = 00, followed by a strobe rise, loads bits[23:2] into `main_word`.
- R3: A 24-bit word with address 10 loads bits[23:2] into `aux_word`, and one with address 11 loads them into `ctrl_word`.
- R4: A 24-bit word with address 01 changes no output when it is strobed. Its bits[23:2] appear on `stage_word` only when a later main (address 00) or extended main word is strobed.
- R5: A 32-bit word, whatever its address bits, loads bits[23:2] into `main_word` and bits[31:24] into `cn_word`.
- R6: `speedup` rises after the strobe rises on a main or extended main word and stays high while the strobe is high. It falls once the strobe is low, and it stays low for strobes of addresses 01, 10 and 11.
- R7: Serial clock pulses while the strobe is high shift no bits and are not counted, so a word sent after the strobe falls loads correctly.
- R8: A strobe after a bit count other than 24 or 32 changes no output and clears the bit count, so the next complete word loads normally.
- R9: A 24-bit main word leaves `cn_word` unchanged.
- R10: When two staged words are strobed before a main word, `stage_word` takes the later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_strobe | input | 1 | Load strobe, acts on its rising edge |
| main_word | output | 22 | Main divider field |
| cn_word | output | 8 | Proportional-current scale from the extended main word |
| stage_word | output | 22 | Double-buffered staged word |
| aux_word | output | 22 | Auxiliary synthesiser word |
| ctrl_word | output | 22 | Control word |
| speedup | output | 1 | Fast-lock speed-up window |

## Verification
The hardest case to reach from the ports is a serial clock that keeps toggling while the strobe is high. Such pulses leave no mark of their own, because the strobe rise has already cleared the counter. The stimulus therefore raises the strobe with no preceding bits, pulses the serial clock with data high, lowers the strobe and sends a full 24-bit word. Any counted pulse would push the count past 24, and that word would then be dropped. The bench uses the same method for malformed lengths: a 20-bit burst is strobed, and then a full word must still land.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      WA_MAIN  = 2'b00,
      WA_STAGE = 2'b01,
      WA_AUX   = 2'b10,
      WA_CTRL  = 2'b11
   } word_addr_e;

   typedef struct packed {
      logic main;
      logic stage;
      logic aux;
      logic ctrl;
   } load_vec_t;
endpackage

// File: rtl/synth_prog_sync.sv
module synth_prog_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '0;
            end else begin
               pipe[0] <= d_in;
               for (int i = 1; i < STAGES; i++) begin
                  pipe[i] <= pipe[i-1];
               end
            end
         end
         assign d_out = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/synth_prog_shift.sv
module synth_prog_shift #(
   parameter int LONG_BITS = 32,
   parameter int CNT_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 s_data,
   input  logic                 s_clk,
   input  logic                 s_stb,
   output logic [LONG_BITS-1:0] shreg,
   output logic [CNT_W-1:0]     bit_cnt,
   output logic                 stb_rise
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LONG_BITS + 1);

   logic clk_q;
   logic stb_q;
   logic clk_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
         stb_q <= 1'b0;
      end else begin
         clk_q <= s_clk;
         stb_q <= s_stb;
      end
   end

   assign clk_rise = s_clk & ~clk_q;
   assign stb_rise = s_stb & ~stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (stb_rise) begin
         bit_cnt <= '0;
      end else if (clk_rise && !s_stb) begin
         shreg <= {shreg[LONG_BITS-2:0], s_data};
         if (bit_cnt != CNT_SAT) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
   import synth_prog_pkg::*;
#(
   parameter int WORD_BITS = 24,
   parameter int LONG_BITS = 32,
   parameter int CNT_W     = 6,
   localparam int PAY_W    = WORD_BITS - ADDR_W,
   localparam int EXT_W    = LONG_BITS - WORD_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LONG_BITS-1:0] shreg,
   input  logic [CNT_W-1:0]     bit_cnt,
   input  logic                 stb_rise,
   input  logic                 stb_level,
   output logic [PAY_W-1:0]     main_word,
   output logic [EXT_W-1:0]     cn_word,
   output logic [PAY_W-1:0]     stage_word,
   output logic [PAY_W-1:0]     aux_word,
   output logic [PAY_W-1:0]     ctrl_word,
   output logic                 speedup,
   output logic                 ld_main
);
   logic       is_short;
   logic       is_long;
   word_addr_e addr;
   load_vec_t  ld;
   logic [PAY_W-1:0] payload;
   logic [EXT_W-1:0] ext_field;
   logic [PAY_W-1:0] stage_shadow;

   assign is_short  = (bit_cnt == CNT_W'(WORD_BITS));
   assign is_long   = (bit_cnt == CNT_W'(LONG_BITS));
   assign addr      = word_addr_e'(shreg[ADDR_W-1:0]);
   assign payload   = shreg[WORD_BITS-1:ADDR_W];
   assign ext_field = shreg[LONG_BITS-1:WORD_BITS];

   always_comb begin
      ld = '0;
      if (stb_rise) begin
         if (is_long) begin
            ld.main = 1'b1;
         end else if (is_short) begin
            unique case (addr)
               WA_MAIN:  ld.main  = 1'b1;
               WA_STAGE: ld.stage = 1'b1;
               WA_AUX:   ld.aux   = 1'b1;
               WA_CTRL:  ld.ctrl  = 1'b1;
               default:  ld       = '0;
            endcase
         end
      end
   end

   assign ld_main = ld.main;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_word    <= '0;
         cn_word      <= '0;
         stage_word   <= '0;
         stage_shadow <= '0;
         aux_word     <= '0;
         ctrl_word    <= '0;
      end else begin
         if (ld.main) begin
            main_word  <= payload;
            stage_word <= stage_shadow;
            if (is_long) begin
               cn_word <= ext_field;
            end
         end
         if (ld.stage) stage_shadow <= payload;
         if (ld.aux)   aux_word     <= payload;
         if (ld.ctrl)  ctrl_word    <= payload;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         speedup <= 1'b0;
      end else if (ld.main) begin
         speedup <= 1'b1;
      end else if (!stb_level) begin
         speedup <= 1'b0;
      end
   end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
   import synth_prog_pkg::*;
#(
   parameter int WORD_BITS   = 24,
   parameter int LONG_BITS   = 32,
   parameter int SYNC_STAGES = 2,
   localparam int PAY_W      = WORD_BITS - ADDR_W,
   localparam int EXT_W      = LONG_BITS - WORD_BITS,
   localparam int CNT_W      = $clog2(LONG_BITS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_data,
   input  logic             ser_clk,
   input  logic             ser_strobe,
   output logic [PAY_W-1:0] main_word,
   output logic [EXT_W-1:0] cn_word,
   output logic [PAY_W-1:0] stage_word,
   output logic [PAY_W-1:0] aux_word,
   output logic [PAY_W-1:0] ctrl_word,
   output logic             speedup
);
   generate
      if (WORD_BITS <= ADDR_W) begin : g_bad_word
         $error("WORD_BITS must exceed the address width");
      end
      if (LONG_BITS <= WORD_BITS) begin : g_bad_long
         $error("LONG_BITS must exceed WORD_BITS");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [2:0]           sync_q;
   logic [LONG_BITS-1:0] shreg;
   logic [CNT_W-1:0]     bit_cnt;
   logic                 stb_rise;
   logic                 ld_main;

   synth_prog_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({ser_strobe, ser_clk, ser_data}),
      .d_out (sync_q)
   );

   synth_prog_shift #(
      .LONG_BITS (LONG_BITS),
      .CNT_W     (CNT_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_data   (sync_q[0]),
      .s_clk    (sync_q[1]),
      .s_stb    (sync_q[2]),
      .shreg    (shreg),
      .bit_cnt  (bit_cnt),
      .stb_rise (stb_rise)
   );

   synth_prog_regs #(
      .WORD_BITS (WORD_BITS),
      .LONG_BITS (LONG_BITS),
      .CNT_W     (CNT_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .shreg      (shreg),
      .bit_cnt    (bit_cnt),
      .stb_rise   (stb_rise),
      .stb_level  (sync_q[2]),
      .main_word  (main_word),
      .cn_word    (cn_word),
      .stage_word (stage_word),
      .aux_word   (aux_word),
      .ctrl_word  (ctrl_word),
      .speedup    (speedup),
      .ld_main    (ld_main)
   );
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
   parameter int LONG_BITS = 32,
   parameter int CNT_W     = 6,
   parameter int PAY_W     = 22,
   parameter int EXT_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stb_level,
   input logic             stb_rise,
   input logic             ld_main,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [PAY_W-1:0] stage_word,
   input logic [PAY_W-1:0] aux_word,
   input logic [PAY_W-1:0] ctrl_word,
   input logic [EXT_W-1:0] cn_word,
   input logic             speedup
);
   AST_SPEEDUP_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      speedup |-> $past(stb_level)); // R6

   AST_STAGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_main |=> $stable(stage_word)); // R4

   AST_CN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_main |=> $stable(cn_word)); // R5

   AST_NO_COUNT_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_level && !stb_rise) |=> $stable(bit_cnt)); // R7

   AST_WORKING_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_rise |=> ($stable(aux_word) && $stable(ctrl_word))); // R3

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(LONG_BITS + 1)); // R8
endmodule

bind synth_prog_if synth_prog_if_chk #(
   .LONG_BITS (LONG_BITS),
   .CNT_W     (CNT_W),
   .PAY_W     (PAY_W),
   .EXT_W     (EXT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stb_level  (sync_q[2]),
   .stb_rise   (stb_rise),
   .ld_main    (ld_main),
   .bit_cnt    (bit_cnt),
   .stage_word (stage_word),
   .aux_word   (aux_word),
   .ctrl_word  (ctrl_word),
   .cn_word    (cn_word),
   .speedup    (speedup)
);

// File: tb/synth_prog_if_tb.sv
module synth_prog_if_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_strobe = 1'b0;
   logic [21:0] main_word, stage_word, aux_word, ctrl_word;
   logic [7:0]  cn_word;
   logic        speedup;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   synth_prog_if u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_data   (ser_data),
      .ser_clk    (ser_clk),
      .ser_strobe (ser_strobe),
      .main_word  (main_word),
      .cn_word    (cn_word),
      .stage_word (stage_word),
      .aux_word   (aux_word),
      .ctrl_word  (ctrl_word),
      .speedup    (speedup)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         ser_data = v[i];
         repeat (4) @(negedge clk);
         ser_clk = 1'b1;
         repeat (4) @(negedge clk);
         ser_clk = 1'b0;
      end
   endtask

   task automatic strobe(input logic exp_speed, input string req);
      repeat (4) @(negedge clk);
      ser_strobe = 1'b1;
      repeat (8) @(negedge clk);
      check(req, speedup, exp_speed);
      ser_strobe = 1'b0;
      repeat (8) @(negedge clk);
      check(req, speedup, 1'b0);
   endtask

   task automatic send24(input logic [21:0] pay, input logic [1:0] addr, input logic spd, input string req);
      send_bits({8'h00, pay, addr}, 24);
      strobe(spd, req);
   endtask

   task automatic t_reset();
      check("R1 main", main_word, 0);
      check("R1 cn", cn_word, 0);
      check("R1 stage", stage_word, 0);
      check("R1 aux", aux_word, 0);
      check("R1 ctrl", ctrl_word, 0);
      check("R1 speedup", speedup, 0);
   endtask

   task automatic t_main();
      send24(22'h2A5C31, 2'b00, 1'b1, "R6 main speedup");
      check("R2 main", main_word, 22'h2A5C31);
      check("R9 cn untouched", cn_word, 0);
   endtask

   task automatic t_aux_ctrl();
      send24(22'h15F00D, 2'b10, 1'b0, "R6 aux no speedup");
      check("R3 aux", aux_word, 22'h15F00D);
      send24(22'h0ABCDE, 2'b11, 1'b0, "R6 ctrl no speedup");
      check("R3 ctrl", ctrl_word, 22'h0ABCDE);
      check("R3 aux kept", aux_word, 22'h15F00D);
   endtask

   task automatic t_stage();
      send24(22'h1234AB, 2'b01, 1'b0, "R6 stage no speedup");
      check("R4 stage held", stage_word, 0);
      check("R4 main held", main_word, 22'h2A5C31);
      send24(22'h000111, 2'b00, 1'b1, "R6 main speedup");
      check("R4 stage moved", stage_word, 22'h1234AB);
      check("R2 main", main_word, 22'h000111);
   endtask

   task automatic t_stage_twice();
      send24(22'h3C3C3C, 2'b01, 1'b0, "R10 first");
      send24(22'h0F0F0F, 2'b01, 1'b0, "R10 second");
      check("R10 still held", stage_word, 22'h1234AB);
      send24(22'h222222, 2'b00, 1'b1, "R10 main");
      check("R10 later wins", stage_word, 22'h0F0F0F);
   endtask

   task automatic t_long();
      send_bits({8'hC7, 22'h155555, 2'b01}, 32);
      strobe(1'b1, "R6 long speedup");
      check("R5 main", main_word, 22'h155555);
      check("R5 cn", cn_word, 8'hC7);
      send24(22'h001234, 2'b00, 1'b1, "R9 main");
      check("R9 cn kept", cn_word, 8'hC7);
   endtask

   task automatic t_clk_in_strobe();
      repeat (4) @(negedge clk);
      ser_strobe = 1'b1;
      ser_data = 1'b1;
      repeat (6) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         ser_clk = 1'b1;
         repeat (4) @(negedge clk);
         ser_clk = 1'b0;
         repeat (4) @(negedge clk);
      end
      ser_strobe = 1'b0;
      repeat (8) @(negedge clk);
      check("R7 ctrl untouched", ctrl_word, 22'h0ABCDE);
      send24(22'h03A5A5, 2'b11, 1'b0, "R7 word");
      check("R7 ctrl loaded", ctrl_word, 22'h03A5A5);
   endtask

   task automatic t_bad_len();
      send_bits(32'h000F_FFFE, 20);
      strobe(1'b0, "R8 bad no speedup");
      check("R8 aux kept", aux_word, 22'h15F00D);
      check("R8 main kept", main_word, 22'h001234);
      check("R8 ctrl kept", ctrl_word, 22'h03A5A5);
      send24(22'h2BCDEF, 2'b10, 1'b0, "R8 next");
      check("R8 next loads", aux_word, 22'h2BCDEF);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_main();
      t_aux_ctrl();
      t_stage();
      t_stage_twice();
      t_long();
      t_clk_in_strobe();
      t_bad_len();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule